// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers 32 external interrupt request lines and offers the processor one interrupt at a time, together with its vector number. The vector is not programmable. Line n always arrives as vector n+32, and a higher vector always wins. The controller keeps a pending set and an in-service set. A request from a higher priority class can preempt a handler that is already running. The running interrupt is retired when software writes the end-of-interrupt register.

Each line has a small configuration entry holding a mask and a trigger mode. Software reaches the entry through an index register and a data window, which sit on a simple single-cycle register bus. The index uses a scrambled encoding of the line number. A task-priority register sets a class threshold below which nothing is delivered.

Top module: `vic_fixed_top`

## Requirements
- R1: While `int_req` is high, `int_vec` equals the delivered line number plus 32, so it lies in 32..63. While `int_req` is low, `int_vec` is 0.
- R2: The candidate is the highest-numbered unmasked pending line. Its class is vector[7:4]. It is delivered only when that class is strictly greater than the class of the highest in-service vector, where an empty in-service set counts as class 0. As a result, a class-3 line preempts a class-2 handler, and a request of the same or lower class waits.
- R3: Delivery also requires the candidate class to be strictly greater than the task-priority register bits [7:4]. That register is at bus address 2, holds 8 bits, and reads back what was written.
- R4: An `int_ack` pulse while `int_req` is high does three things: it sets the in-service bit of the delivered line, it clears that line's edge-pending bit, and it drops `int_req` in the next cycle. An `int_ack` pulse while `int_req` is low has no effect.
- R5: Any write to address 3 (end of interrupt) clears only the highest set in-service bit, whatever the write data. The highest remaining eligible request is then delivered one cycle later.
- R6: Reading address 4 returns the in-service set, with bit k standing for vector 32+k.
- R7: Address 0 holds an 8-bit index. Line n is selected by index {n[4:3], 0, n[2:0], 0}, that is, bits 6:5 = n[4:3] and bits 3:1 = n[2:0]. An index with bit 0, bit 4 or bit 7 set selects no line. Through the window at address 1, such an index reads 0 and ignores writes.
- R8: A configuration entry has the mask at bit 16 and level mode at bit 15, where 1 means level and 0 means edge. All other bits read 0. After reset every line is masked and in edge mode.
- R9: An edge-mode line sets its pending bit on a 0-to-1 input transition seen while it is unmasked. The bit stays set until that line is acknowledged. A transition seen while the line is masked is not recorded.
- R10: A level-mode line is pending exactly while its input is high and it is unmasked.
- R11: Reading address 5 returns the pending set, bit n for line n, with the same bit-to-vector mapping as R6.
- R12: Reset is synchronous and active high. After reset `int_req` is 0, `int_vec` is 0, the in-service set is empty, the index is 0 and the task priority is 0.
- R13: A read returns its data on `bus_rdata` one cycle after `bus_rd`. In any cycle that does not follow a read, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | External request lines, bit n is line n |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register select: 0 index, 1 window, 2 task priority, 3 end of interrupt, 4 in-service, 5 pending |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| int_req | output | 1 | Interrupt offered to the processor |
| int_vec | output | 8 | Vector of the offered interrupt |
| int_ack | input | 1 | Processor takes the offered interrupt |

## Verification
An isolated edge pulse on one line tells latching apart from following the input. A held level input shows the opposite, and it shows that dropping the input withdraws the request. A class-3 pulse arriving while a class-2 handler runs separates real preemption from mere ordering. A lower line left waiting through two end-of-interrupt writes shows that each write retires only the top in-service bit. Index values with the reserved bits set would alias line 0 if the decode were loose, so they catch a sloppy index decode. Long stretches of random line toggles, acknowledges, threshold changes and reconfiguration are then compared cycle by cycle against a behavioural model.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int REG_ADDR_W    = 3;
  localparam int CFG_MASK_BIT  = 16;
  localparam int CFG_LEVEL_BIT = 15;
  localparam int CLS_LSB       = 4;

  typedef enum logic [REG_ADDR_W-1:0] {
    A_SEL   = 3'd0,
    A_WIN   = 3'd1,
    A_TPR   = 3'd2,
    A_EOI   = 3'd3,
    A_INSVC = 3'd4,
    A_REQ   = 3'd5
  } vic_reg_e;
endpackage

// File: rtl/vic_msb_find.sv
module vic_msb_find #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  // highest set bit wins: later iterations overwrite earlier ones
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vic_line_bank.sv
module vic_line_bank #(
  parameter int LINES = 32,
  parameter int LW    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] irq_in,
  input  logic             cfg_we,
  input  logic [LW-1:0]    cfg_line,
  input  logic             cfg_mask,
  input  logic             cfg_level,
  input  logic [LINES-1:0] ack_clr,
  output logic [LINES-1:0] req,
  output logic [LINES-1:0] mask_o,
  output logic [LINES-1:0] level_o
);
  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic mask_q, level_q, prev_q, epend_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          mask_q  <= 1'b1;
          level_q <= 1'b0;
          prev_q  <= 1'b0;
          epend_q <= 1'b0;
        end else begin
          prev_q <= irq_in[g];
          if (cfg_we && cfg_line == LW'(g)) begin
            mask_q  <= cfg_mask;
            level_q <= cfg_level;
          end
          if (ack_clr[g]) epend_q <= 1'b0;
          // a fresh edge in the acknowledge cycle is kept
          if (!level_q && !mask_q && irq_in[g] && !prev_q) epend_q <= 1'b1;
        end
      end

      assign req[g]     = level_q ? (irq_in[g] & ~mask_q) : epend_q;
      assign mask_o[g]  = mask_q;
      assign level_o[g] = level_q;
    end
  endgenerate
endmodule

// File: rtl/vic_prio_sel.sv
module vic_prio_sel import vic_pkg::*; #(
  parameter int LINES    = 32,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32,
  parameter int LW       = $clog2(LINES),
  parameter int CW       = VEC_W - CLS_LSB
) (
  input  logic [LINES-1:0] req,
  input  logic [LINES-1:0] mask,
  input  logic [LINES-1:0] isr,
  input  logic [CW-1:0]    tpr_cls,
  output logic             deliver,
  output logic [VEC_W-1:0] cand_vec,
  output logic             isr_any,
  output logic [LW-1:0]    isr_top
);
  logic [LINES-1:0] pend;
  logic             pend_any;
  logic [LW-1:0]    pend_idx;
  logic [VEC_W-1:0] isr_vec;
  logic [CW-1:0]    cand_cls, isr_cls;

  assign pend = req & ~mask;

  vic_msb_find #(.W(LINES), .IW(LW)) u_pend_msb (
    .vec(pend), .found(pend_any), .idx(pend_idx)
  );
  vic_msb_find #(.W(LINES), .IW(LW)) u_isr_msb (
    .vec(isr), .found(isr_any), .idx(isr_top)
  );

  assign cand_vec = VEC_W'(VEC_BASE) + VEC_W'(pend_idx);
  assign isr_vec  = VEC_W'(VEC_BASE) + VEC_W'(isr_top);
  assign cand_cls = cand_vec[VEC_W-1:CLS_LSB];
  assign isr_cls  = isr_any ? isr_vec[VEC_W-1:CLS_LSB] : '0;
  assign deliver  = pend_any && (cand_cls > tpr_cls) && (cand_cls > isr_cls);

  wire unused_lo = ^isr_vec[CLS_LSB-1:0];
endmodule

// File: rtl/vic_regfile.sv
module vic_regfile import vic_pkg::*; #(
  parameter int LINES  = 32,
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8,
  parameter int LW     = $clog2(LINES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [LINES-1:0]      mask_i,
  input  logic [LINES-1:0]      level_i,
  input  logic [LINES-1:0]      isr_i,
  input  logic [LINES-1:0]      req_i,
  output logic                  cfg_we,
  output logic [LW-1:0]         cfg_line,
  output logic                  cfg_mask,
  output logic                  cfg_level,
  output logic                  eoi_pulse,
  output logic [VEC_W-1:0]      tpr_o
);
  localparam int SEL_W = 8;

  logic [SEL_W-1:0]  sel_q;
  logic [VEC_W-1:0]  tpr_q;
  logic              sel_ok;
  logic [LW-1:0]     sel_line;
  logic [DATA_W-1:0] win_rd, rd_mux;

  // scrambled index: line[2:0] at bits 3:1, line[4:3] at bits 6:5
  assign sel_line = {sel_q[LW+1:5], sel_q[3:1]};
  assign sel_ok   = !sel_q[0] && !sel_q[4] && (sel_q[SEL_W-1:LW+2] == '0);

  always_comb begin
    win_rd = '0;
    if (sel_ok) begin
      win_rd[CFG_MASK_BIT]  = mask_i[sel_line];
      win_rd[CFG_LEVEL_BIT] = level_i[sel_line];
    end
  end

  always_comb begin
    case (bus_addr)
      A_SEL:   rd_mux = DATA_W'(sel_q);
      A_WIN:   rd_mux = win_rd;
      A_TPR:   rd_mux = DATA_W'(tpr_q);
      A_INSVC: rd_mux = DATA_W'(isr_i);
      A_REQ:   rd_mux = DATA_W'(req_i);
      default: rd_mux = '0;
    endcase
  end

  assign cfg_we    = bus_wr && (bus_addr == A_WIN) && sel_ok;
  assign cfg_line  = sel_line;
  assign cfg_mask  = bus_wdata[CFG_MASK_BIT];
  assign cfg_level = bus_wdata[CFG_LEVEL_BIT];
  assign eoi_pulse = bus_wr && (bus_addr == A_EOI);
  assign tpr_o     = tpr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      tpr_q     <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && bus_addr == A_SEL) sel_q <= bus_wdata[SEL_W-1:0];
      if (bus_wr && bus_addr == A_TPR) tpr_q <= bus_wdata[VEC_W-1:0];
      bus_rdata <= bus_rd ? rd_mux : '0;
    end
  end

  wire unused_wdata = ^bus_wdata;
endmodule

// File: rtl/vic_fixed_top.sv
module vic_fixed_top import vic_pkg::*; #(
  parameter int LINES    = 32,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32,
  parameter int DATA_W   = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LINES-1:0]      irq_in,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  int_req,
  output logic [VEC_W-1:0]      int_vec,
  input  logic                  int_ack
);
  localparam int LW = $clog2(LINES);
  localparam int CW = VEC_W - CLS_LSB;

  logic [LINES-1:0] req, mask, level, isr_q, ack_clr, eoi_clr;
  logic             cfg_we, cfg_mask, cfg_level, eoi_pulse;
  logic [LW-1:0]    cfg_line, isr_top, ack_line;
  logic [VEC_W-1:0] tpr_val, cand_vec, ack_off;
  logic             deliver, isr_any, ack_ok;

  vic_line_bank #(.LINES(LINES), .LW(LW)) u_lines (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .cfg_we(cfg_we), .cfg_line(cfg_line), .cfg_mask(cfg_mask), .cfg_level(cfg_level),
    .ack_clr(ack_clr), .req(req), .mask_o(mask), .level_o(level)
  );

  vic_prio_sel #(.LINES(LINES), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .LW(LW), .CW(CW)) u_prio (
    .req(req), .mask(mask), .isr(isr_q), .tpr_cls(tpr_val[VEC_W-1:CLS_LSB]),
    .deliver(deliver), .cand_vec(cand_vec), .isr_any(isr_any), .isr_top(isr_top)
  );

  vic_regfile #(.LINES(LINES), .DATA_W(DATA_W), .VEC_W(VEC_W), .LW(LW)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mask_i(mask), .level_i(level), .isr_i(isr_q), .req_i(req),
    .cfg_we(cfg_we), .cfg_line(cfg_line), .cfg_mask(cfg_mask), .cfg_level(cfg_level),
    .eoi_pulse(eoi_pulse), .tpr_o(tpr_val)
  );

  // acknowledge acts on the vector presented in this cycle
  assign ack_ok   = int_ack && int_req;
  assign ack_off  = int_vec - VEC_W'(VEC_BASE);
  assign ack_line = ack_off[LW-1:0];
  assign ack_clr  = ack_ok ? (LINES'(1) << ack_line) : '0;
  assign eoi_clr  = (eoi_pulse && isr_any) ? (LINES'(1) << isr_top) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q   <= '0;
      int_req <= 1'b0;
      int_vec <= '0;
    end else begin
      isr_q   <= (isr_q & ~eoi_clr) | ack_clr;
      // hold off one cycle after an acknowledge so the new state settles
      int_req <= deliver && !ack_ok;
      int_vec <= (deliver && !ack_ok) ? cand_vec : '0;
    end
  end

  wire unused_off = ^ack_off;
endmodule

// File: rtl/vic_checks.sv
module vic_checks import vic_pkg::*; #(
  parameter int LINES    = 32,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32,
  parameter int DATA_W   = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  int_req,
  input logic                  int_ack,
  input logic [VEC_W-1:0]      int_vec,
  input logic [LINES-1:0]      isr_q,
  input logic [VEC_W-1:0]      tpr_val,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [REG_ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0]     bus_rdata
);
  localparam int CW = VEC_W - CLS_LSB;
  localparam int LW = $clog2(LINES);
  logic [CW-1:0] isr_cls;

  always_comb begin
    isr_cls = '0;
    for (int i = 0; i < LINES; i++)
      if (isr_q[i]) isr_cls = CW'((VEC_BASE + i) >> CLS_LSB);
  end

  AST_VEC_WINDOW: assert property (@(posedge clk) disable iff (rst)
    int_req |-> (int_vec >= VEC_W'(VEC_BASE) && int_vec <= VEC_W'(VEC_BASE + LINES - 1))); // R1
  AST_QUIET_VEC: assert property (@(posedge clk) disable iff (rst)
    !int_req |-> int_vec == '0); // R1
  AST_ABOVE_INSVC: assert property (@(posedge clk) disable iff (rst)
    int_req |-> int_vec[VEC_W-1:CLS_LSB] > isr_cls); // R2
  AST_ABOVE_TPR: assert property (@(posedge clk) disable iff (rst)
    int_req |-> int_vec[VEC_W-1:CLS_LSB] > $past(tpr_val[VEC_W-1:CLS_LSB])); // R3
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    (int_ack && int_req) |=> !int_req); // R4
  AST_ACK_MARKS: assert property (@(posedge clk) disable iff (rst)
    (int_ack && int_req) |=> isr_q[$past(int_vec[LW-1:0])]); // R4
  AST_EOI_ONE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_EOI && !(int_ack && int_req) && isr_q != '0)
      |=> $countones(isr_q) == $countones($past(isr_q)) - 1); // R5
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0); // R13
endmodule

bind vic_fixed_top vic_checks #(
  .LINES(LINES), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .int_req(int_req), .int_ack(int_ack), .int_vec(int_vec),
  .isr_q(isr_q), .tpr_val(tpr_val), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/vic_fixed_top_bench.sv
`timescale 1ns/1ps
module vic_fixed_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        int_req;
  logic [7:0]  int_vec;
  logic        int_ack = 1'b0;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  vic_fixed_top u_vic_fixed_top (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .int_req(int_req), .int_vec(int_vec), .int_ack(int_ack)
  );

  // ---------------- behavioural reference ----------------
  bit          m_mask[32], m_level[32], m_prev[32], m_ep[32];
  bit [31:0]   m_isr, m_rq, m_nisr;
  int          m_tpr, m_sel, m_vec, m_cand, m_top, m_line;
  bit          m_req, m_dlv, m_ackok, m_ok;
  bit [31:0]   m_rd;

  always @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < 32; l++) begin
        m_mask[l] = 1; m_level[l] = 0; m_prev[l] = 0; m_ep[l] = 0;
      end
      m_isr = 0; m_tpr = 0; m_sel = 0; m_req = 0; m_vec = 0; m_rd = 0;
    end else begin
      for (int l = 0; l < 32; l++)
        m_rq[l] = m_level[l] ? (irq_in[l] && !m_mask[l]) : m_ep[l];
      m_cand = -1; m_top = -1;
      for (int l = 0; l < 32; l++) begin
        if (m_rq[l] && !m_mask[l]) m_cand = l;
        if (m_isr[l]) m_top = l;
      end
      m_dlv = (m_cand >= 0) && ((m_cand + 32) / 16 > m_tpr / 16) &&
              ((m_cand + 32) / 16 > (m_top < 0 ? 0 : (m_top + 32) / 16));
      m_ackok = int_ack && m_req;
      m_ok   = (m_sel % 2 == 0) && ((m_sel / 16) % 2 == 0) && (m_sel < 128);
      m_line = ((m_sel / 32) % 4) * 8 + (m_sel / 2) % 8;
      if (bus_rd) begin
        case (bus_addr)
          3'd0: m_rd = m_sel;
          3'd1: m_rd = m_ok ? ((m_mask[m_line] ? 32'h10000 : 0) | (m_level[m_line] ? 32'h8000 : 0)) : 0;
          3'd2: m_rd = m_tpr;
          3'd4: m_rd = m_isr;
          3'd5: m_rd = m_rq;
          default: m_rd = 0;
        endcase
      end else m_rd = 0;
      m_nisr = m_isr;
      if (bus_wr && bus_addr == 3 && m_top >= 0) m_nisr[m_top] = 0;
      if (m_ackok) m_nisr[m_vec - 32] = 1;
      for (int l = 0; l < 32; l++) begin
        if (m_ackok && l == m_vec - 32) m_ep[l] = 0;
        if (!m_level[l] && !m_mask[l] && irq_in[l] && !m_prev[l]) m_ep[l] = 1;
        m_prev[l] = irq_in[l];
      end
      if (bus_wr && bus_addr == 1 && m_ok) begin
        m_mask[m_line]  = bus_wdata[16];
        m_level[m_line] = bus_wdata[15];
      end
      if (bus_wr && bus_addr == 0) m_sel = bus_wdata[7:0];
      if (bus_wr && bus_addr == 2) m_tpr = bus_wdata[7:0];
      m_isr = m_nisr;
      m_req = m_dlv && !m_ackok;
      m_vec = m_req ? m_cand + 32 : 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 int_req vs model", {31'b0, int_req}, {31'b0, m_req});
      chk("R1 int_vec vs model", {24'b0, int_vec}, m_vec);
      chk("R13 rdata vs model", bus_rdata, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] idx_of(input int n);
    return ((n & 7) << 1) | ((n & 24) << 2);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 0;
  endtask

  task automatic wr_cfg(input int n, input logic [31:0] d);
    wr(3'd0, idx_of(n)); wr(3'd1, d);
  endtask

  task automatic rd_cfg(input int n, output logic [31:0] d);
    wr(3'd0, idx_of(n)); rd(3'd1, d);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack1();
    int_ack = 1; tick(1); int_ack = 0;
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    tick(4);
    rst = 0;
    tick(1);
    // R12 reset state
    chk("R12 int_req", {31'b0, int_req}, 0);
    chk("R12 int_vec", {24'b0, int_vec}, 0);
    rd(3'd4, v); chk("R12 in-service empty", v, 0);
    rd(3'd2, v); chk("R12 tpr zero", v, 0);
    rd(3'd0, v); chk("R12 index zero", v, 0);
    rd_cfg(0, v); chk("R8 reset entry masked edge", v, 32'h10000);

    // configuration
    wr_cfg(5, 0); wr_cfg(20, 0); wr_cfg(3, 32'h8000); wr_cfg(7, 32'hFFFF_FFFF);
    rd_cfg(7, v); chk("R8 only mask and level bits kept", v, 32'h18000);
    rd_cfg(3, v); chk("R8 level entry", v, 32'h8000);
    rd_cfg(20, v); chk("R7 line 20 index", v, 0);
    rd_cfg(4, v); chk("R7 line 4 untouched", v, 32'h10000);
    wr(3'd0, 32'h01); wr(3'd1, 0); rd(3'd1, v); chk("R7 bit0 index reads zero", v, 0);
    wr(3'd0, 32'h10); wr(3'd1, 0); rd(3'd1, v); chk("R7 bit4 index reads zero", v, 0);
    rd_cfg(0, v); chk("R7 bad index write ignored", v, 32'h10000);

    // edge pulse on line 5
    irq_in[5] = 1; tick(1); irq_in[5] = 0; tick(2);
    chk("R9 edge latched int_req", {31'b0, int_req}, 1);
    chk("R1 vector 37", {24'b0, int_vec}, 37);
    rd(3'd5, v); chk("R11 pending shows line 5", v, 32'h20);
    ack1();
    chk("R4 int_req drops after ack", {31'b0, int_req}, 0);
    rd(3'd4, v); chk("R6 in-service bit 5", v, 32'h20);
    rd(3'd5, v); chk("R4 edge pending cleared", v, 0);

    // level line 3, same class as service: must wait
    irq_in[3] = 1; tick(3);
    chk("R2 same class waits", {31'b0, int_req}, 0);
    rd(3'd5, v); chk("R10 level pending", v, 32'h08);

    // class 3 preempts
    irq_in[20] = 1; tick(1); irq_in[20] = 0; tick(2);
    chk("R2 preempt int_req", {31'b0, int_req}, 1);
    chk("R2 preempt vector 52", {24'b0, int_vec}, 52);
    ack1();
    rd(3'd4, v); chk("R6 nested in-service", v, 32'h0010_0020);

    // end of interrupt
    wr(3'd3, 32'hDEAD_BEEF);
    rd(3'd4, v); chk("R5 top bit retired", v, 32'h20);
    tick(2);
    chk("R5 lower still held", {31'b0, int_req}, 0);
    wr(3'd3, 0);
    rd(3'd4, v); chk("R5 in-service empty", v, 0);
    tick(2);
    chk("R5 waiting line delivered", {31'b0, int_req}, 1);
    chk("R5 vector 35", {24'b0, int_vec}, 35);

    // threshold
    wr(3'd2, 32'h20); tick(2);
    chk("R3 threshold blocks class 2", {31'b0, int_req}, 0);
    rd(3'd2, v); chk("R3 tpr readback", v, 32'h20);
    wr(3'd2, 32'h1F); tick(2);
    chk("R3 threshold below class 2", {31'b0, int_req}, 1);
    irq_in[3] = 0; tick(2);
    chk("R10 level withdrawn", {31'b0, int_req}, 0);

    // masked edge is not recorded
    wr_cfg(5, 32'h10000);
    irq_in[5] = 1; tick(1); irq_in[5] = 0; tick(2);
    rd(3'd5, v); chk("R9 masked edge ignored", v, 0);
    wr_cfg(5, 0); tick(3);
    chk("R9 no late delivery", {31'b0, int_req}, 0);

    // stray acknowledge
    ack1();
    rd(3'd4, v); chk("R4 stray ack ignored", v, 0);
    wr(3'd2, 0);

    // random traffic compared against the model
    for (int it = 0; it < 6000; it++) begin
      int r;
      irq_in  = irq_in ^ ($urandom & $urandom & $urandom);
      int_ack = int_req && ($urandom % 3 == 0);
      r = $urandom % 40;
      if (r == 0) begin
        int_ack = 0;
        wr_cfg($urandom % 32, (($urandom % 4 == 0) ? 32'h10000 : 0) | (($urandom % 3 == 0) ? 32'h8000 : 0));
      end else if (r == 1) wr(3'd3, $urandom);
      else if (r == 2) wr(3'd2, ($urandom % 4) * 16);
      else if (r == 3) rd(3'd4, v);
      else if (r == 4) rd(3'd5, v);
      else if (r == 5) rd(3'd1, v);
      else if (r == 6) wr(3'd0, $urandom % 256);
      else tick(1);
    end
    int_ack = 0;
    tick(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule